// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block remaps bus addresses that fall inside a fixed memory aperture onto physical pages. The aperture is split into 4 KiB pages. Each page owns one 32-bit table entry: a valid flag in bit 31 and a physical page frame in bits 30:12. A lookup stream takes a bus address and, one cycle later, returns either the physical address (frame joined with the 12-bit page offset) or a fault.

Software reaches the table only indirectly, through three 32-bit registers. It first writes an aperture address into a selection register to pick the entry for that page. It then writes or reads a data register, which acts on the picked entry. A configuration register holds a global enable in bit 0. While the enable is clear, every lookup faults. The configuration register reads back exactly what was last written, so software can use that read as an ordering point. The aperture base (page aligned) and the entry count (a power of two) are parameters.

The lookup side is a valid/ready stream at both ends. A request is accepted on any cycle where `req_valid` and `req_ready` are both high. The response is held in a single output register. That register stays unchanged while the consumer holds `rsp_ready` low, and no new request is accepted during that time. When the consumer takes the response, a new request can be accepted in the same cycle, so the stream runs at one lookup per cycle.

Top module: `aperture_remap_top`

## Requirements
- R1: After reset, the configuration register, the selection register and every table entry read 0, and `rsp_valid` is low.
- R2: The register offset decodes as follows: 0x0 is configuration, 0x4 is selection and 0x8 is entry data. Configuration and selection read back the last value written to them. A write to any other offset changes nothing, and a read from any other offset returns 0.
- R3: The selection register picks entry index (sel - BASE) >> 12. A write to offset 0x8 stores all 32 data bits into that entry. Lookups accepted after the write's clock edge use the new value.
- R4: A read of offset 0x8 returns the selected entry. If the selection register holds an address outside the aperture, a write to 0x8 changes no entry and a read of 0x8 returns 0.
- R5: Entry format: bit 31 is the valid flag and bits 30:12 are the physical frame. Writing 0 makes an entry invalid.
- R6: The translation enable is configuration bit 0. While it is 0, every accepted lookup returns a fault.
- R7: A lookup faults when its address is below BASE or at or above BASE + ENTRIES*4096, or when its entry's valid flag is clear. A faulting response carries `rsp_addr` = 0.
- R8: A lookup that does not fault returns `rsp_addr` = {1'b0, entry[30:12], req_addr[11:0]}.
- R9: `req_ready` = !rsp_valid || rsp_ready. The response of a request accepted at one clock edge is valid after that edge. The response holds unchanged while `rsp_valid` is high and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_offs | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_offs`, combinational |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Lookup faulted |

## Verification
The hold property assumes that the consumer drives `rsp_ready` as a plain level. It also assumes that a held response is the only thing that can stall the request side. The write-effect properties assume that register writes carry no X. They also assume that no write lands on the same edge as a lookup whose result the bench checks.

The bench drives every input on the falling edge, never on the rising edge. It keeps register writes and checked lookups in separate cycles, and it holds `reg_wr` low unless it is issuing a write. It raises and lowers `rsp_ready` only in the dedicated stall sequence, so each lookup's expected response is tied to one accepted request.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int REG_W = 32;
  localparam int OFFS_W = 4;
  localparam logic [OFFS_W-1:0] OFFS_CFG  = 4'h0;
  localparam logic [OFFS_W-1:0] OFFS_SEL  = 4'h4;
  localparam logic [OFFS_W-1:0] OFFS_DATA = 4'h8;
  localparam int VALID_BIT = 31;
endpackage

// File: rtl/remap_win_decode.sv
// Maps an address onto a page index and a window hit, using only page bits.
module remap_win_decode #(
  parameter logic [31:0] BASE = 32'h0,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W = 4
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam int PN_W = 32 - PAGE_BITS;

  logic [PN_W:0] page_diff;

  always_comb begin
    page_diff = {1'b0, addr[31:PAGE_BITS]} - {1'b0, BASE[31:PAGE_BITS]};
    hit = (page_diff[PN_W:IDX_W] == '0);
    idx = page_diff[IDX_W-1:0];
  end
endmodule

// File: rtl/remap_table.sv
module remap_table #(
  parameter int ENTRIES = 16,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int FRAME_W = 31 - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [31:0]        wdata,
  output logic [31:0]        sel_entry,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic               lk_valid,
  output logic [FRAME_W-1:0] lk_frame
);
  logic [31:0] ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent[g] <= '0;
      else if (we && widx == IDX_W'(g)) ent[g] <= wdata;
    end
  end

  always_comb begin
    sel_entry = ent[widx];
    lk_valid  = ent[lk_idx][remap_pkg::VALID_BIT];
    lk_frame  = ent[lk_idx][30:PAGE_BITS];
  end

  // R3: a data write lands in the selected entry
  a_r3_entry_store: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ent[$past(widx)] == $past(wdata));
endmodule

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFFS_W-1:0] reg_offs,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              sel_hit,
  input  logic [REG_W-1:0]  sel_entry,
  output logic [REG_W-1:0]  sel_addr,
  output logic              tbl_we,
  output logic              xlat_en
);
  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sel_q <= '0;
    end else if (reg_wr) begin
      if (reg_offs == OFFS_CFG) cfg_q <= reg_wdata;
      if (reg_offs == OFFS_SEL) sel_q <= reg_wdata;
    end
  end

  always_comb begin
    tbl_we   = reg_wr && (reg_offs == OFFS_DATA) && sel_hit;
    sel_addr = sel_q;
    xlat_en  = cfg_q[0];
    unique case (reg_offs)
      OFFS_CFG:  reg_rdata = cfg_q;
      OFFS_SEL:  reg_rdata = sel_q;
      OFFS_DATA: reg_rdata = sel_hit ? sel_entry : '0;
      default:   reg_rdata = '0;
    endcase
  end

  // R2: configuration holds the last written word
  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_offs == OFFS_CFG) |=> cfg_q == $past(reg_wdata));
  // R2: writes to unknown offsets leave both registers alone
  a_r2_unused_offs: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_offs != OFFS_CFG && reg_offs != OFFS_SEL)
      |=> $stable(cfg_q) && $stable(sel_q));
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup #(
  parameter int PAGE_BITS = 12,
  localparam int FRAME_W = 31 - PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xlat_en,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PAGE_BITS-1:0] req_page_off,
  input  logic                 win_hit,
  input  logic                 ent_valid,
  input  logic [FRAME_W-1:0]   ent_frame,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_addr,
  output logic                 rsp_fault
);
  logic accept;
  logic fault_d;

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    fault_d   = !xlat_en || !win_hit || !ent_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= fault_d;
      rsp_addr  <= fault_d ? '0 : {1'b0, ent_frame, req_page_off};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R6: lookups taken while disabled fault
  a_r6_disabled_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !xlat_en) |=> rsp_valid && rsp_fault);
  // R7: out-of-window lookups fault, faults carry a zero address
  a_r7_window_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !win_hit) |=> rsp_fault);
  a_r7_fault_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_addr == '0);
  // R8: output bit 31 is never set
  a_r8_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_addr[31]);
  // R9: a stalled response holds still
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready)
      |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));
endmodule

// File: rtl/aperture_remap_top.sv
module aperture_remap_top #(
  parameter logic [31:0] BASE = 32'h0,
  parameter int ENTRIES = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_offs,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic        rsp_fault
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int FRAME_W = 31 - PAGE_BITS;

  logic               sel_hit, lk_hit, tbl_we, xlat_en, lk_valid;
  logic [IDX_W-1:0]   sel_idx, lk_idx;
  logic [31:0]        sel_addr, sel_entry;
  logic [FRAME_W-1:0] lk_frame;

  remap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_offs(reg_offs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel_hit(sel_hit),
    .sel_entry(sel_entry), .sel_addr(sel_addr), .tbl_we(tbl_we),
    .xlat_en(xlat_en)
  );

  remap_win_decode #(.BASE(BASE), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_sel_dec (
    .addr(sel_addr), .hit(sel_hit), .idx(sel_idx)
  );

  remap_win_decode #(.BASE(BASE), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_lk_dec (
    .addr(req_addr), .hit(lk_hit), .idx(lk_idx)
  );

  remap_table #(.ENTRIES(ENTRIES), .PAGE_BITS(PAGE_BITS)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(sel_idx), .wdata(reg_wdata),
    .sel_entry(sel_entry), .lk_idx(lk_idx), .lk_valid(lk_valid),
    .lk_frame(lk_frame)
  );

  remap_lookup #(.PAGE_BITS(PAGE_BITS)) u_lookup (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_page_off(req_addr[PAGE_BITS-1:0]),
    .win_hit(lk_hit), .ent_valid(lk_valid), .ent_frame(lk_frame),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault)
  );
endmodule

// File: tb/sim_aperture_remap_top.sv
`timescale 1ns/1ps
module sim_aperture_remap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_offs = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_fault;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] shadow [16];
  logic        en_m = 1'b0;

  always #2 clk = ~clk;

  aperture_remap_top #(.BASE(32'h0), .ENTRIES(16), .PAGE_BITS(12)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_offs(reg_offs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] o, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_offs = o; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] o, output logic [31:0] d);
    @(negedge clk);
    reg_offs = o;
    #1 d = reg_rdata;
  endtask

  function automatic logic [32:0] model(input logic [31:0] a);
    logic [31:0] e;
    if (!en_m || a >= 32'h0001_0000) return {1'b1, 32'h0};
    e = shadow[a[15:12]];
    if (!e[31]) return {1'b1, 32'h0};
    return {1'b0, 1'b0, e[30:12], a[11:0]};
  endfunction

  task automatic lookup(input string tag, input logic [31:0] a);
    logic [32:0] ex;
    ex = model(a);
    @(negedge clk);
    chk("R9 ready when idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 response valid next cycle", {63'd0, rsp_valid}, 64'd1);
    chk(tag, {31'd0, rsp_fault, rsp_addr}, {31'd0, ex});
  endtask

  function automatic logic [31:0] pattern(input int i, input int salt);
    logic [31:0] f;
    f = (32'(i) * 32'h1357 + 32'(salt)) & 32'h7_FFFF;
    return (((i + salt) % 3) != 0 ? 32'h8000_0000 : 32'h0) | (f << 12) | 32'(i);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] fa, fb;
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    reg_read(4'h0, rd); chk("R1 config reset", {32'd0, rd}, 64'd0);
    reg_read(4'h4, rd); chk("R1 select reset", {32'd0, rd}, 64'd0);
    for (int i = 0; i < 16; i++) begin
      reg_write(4'h4, 32'(i) << 12);
      reg_read(4'h8, rd); chk("R1 entry reset", {32'd0, rd}, 64'd0);
    end

    // R2: register readback and unused offsets
    reg_write(4'h0, 32'hA5A5_0000);
    reg_read(4'h0, rd); chk("R2 config readback", {32'd0, rd}, 64'hA5A5_0000);
    reg_write(4'h4, 32'h0000_3ABC);
    reg_read(4'h4, rd); chk("R2 select readback", {32'd0, rd}, 64'h3ABC);
    reg_write(4'hC, 32'hFFFF_FFFF);
    reg_write(4'h2, 32'h1234_5678);
    reg_read(4'hC, rd); chk("R2 unused offset reads 0", {32'd0, rd}, 64'd0);
    reg_read(4'h0, rd); chk("R2 config untouched", {32'd0, rd}, 64'hA5A5_0000);
    reg_read(4'h4, rd); chk("R2 select untouched", {32'd0, rd}, 64'h3ABC);

    // R3/R4/R5: program every entry, then read all back
    for (int i = 0; i < 16; i++) begin
      reg_write(4'h4, (32'(i) << 12) | 32'h7F);
      reg_write(4'h8, pattern(i, 5));
      shadow[i] = pattern(i, 5);
    end
    for (int i = 0; i < 16; i++) begin
      reg_write(4'h4, (32'(i) << 12) | 32'hFFF);
      reg_read(4'h8, rd); chk("R3 R4 entry readback", {32'd0, rd}, {32'd0, shadow[i]});
    end

    // R4: selection outside the window
    reg_write(4'h4, 32'h0001_0000);
    reg_write(4'h8, 32'hFFFF_FFFF);
    reg_read(4'h8, rd); chk("R4 out-of-window read 0", {32'd0, rd}, 64'd0);
    for (int i = 0; i < 16; i++) begin
      reg_write(4'h4, 32'(i) << 12);
      reg_read(4'h8, rd); chk("R4 entries untouched", {32'd0, rd}, {32'd0, shadow[i]});
    end

    // R6: disabled (config bit0 = 0) faults everywhere
    reg_write(4'h0, 32'h0000_0002); en_m = 1'b0;
    for (int i = 0; i < 16; i++) lookup("R6 disabled lookup", (32'(i) << 12) | 32'h123);

    // R7/R8: enabled sweep
    reg_write(4'h0, 32'h0000_0001); en_m = 1'b1;
    for (int i = 0; i < 16; i++) begin
      lookup("R7 R8 sweep off 000", 32'(i) << 12);
      lookup("R7 R8 sweep off ABC", (32'(i) << 12) | 32'hABC);
      lookup("R7 R8 sweep off FFF", (32'(i) << 12) | 32'hFFF);
    end
    lookup("R7 just past window", 32'h0001_0000);
    lookup("R7 far past window", 32'h0001_FFFF);
    lookup("R7 high address", 32'h8000_0000);
    lookup("R7 top address", 32'hFFFF_FFFF);

    // R5: clearing with 0 and remapping
    for (int i = 0; i < 16; i += 2) begin
      reg_write(4'h4, 32'(i) << 12);
      reg_write(4'h8, 32'h0);
      shadow[i] = 32'h0;
    end
    for (int i = 1; i < 16; i += 2) begin
      reg_write(4'h4, 32'(i) << 12);
      reg_write(4'h8, pattern(i, 1) | 32'h8000_0000);
      shadow[i] = pattern(i, 1) | 32'h8000_0000;
    end
    for (int i = 0; i < 16; i++) lookup("R5 remapped sweep", (32'(i) << 12) | 32'h5A5);

    // R9: back-pressure hold and same-cycle refill
    fa = 32'h0000_1234; fb = 32'h0000_3456;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = fa;
    @(negedge clk);
    req_addr = fb;
    chk("R9 first response valid", {63'd0, rsp_valid}, 64'd1);
    chk("R9 stalled not ready", {63'd0, req_ready}, 64'd0);
    chk("R9 first response", {31'd0, rsp_fault, rsp_addr}, {31'd0, model(fa)});
    @(negedge clk);
    chk("R9 held response", {31'd0, rsp_fault, rsp_addr}, {31'd0, model(fa)});
    chk("R9 still not ready", {63'd0, req_ready}, 64'd0);
    rsp_ready = 1'b1;
    #1 chk("R9 ready follows rsp_ready", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 refill valid", {63'd0, rsp_valid}, 64'd1);
    chk("R9 refill response", {31'd0, rsp_fault, rsp_addr}, {31'd0, model(fb)});
    @(negedge clk);
    chk("R9 drained", {63'd0, rsp_valid}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule